// File: doc/BRIEF.md
# Word-Serial CORDIC Engine

This block evaluates the CORDIC shift-and-add recurrence one micro-rotation per enabled clock, reusing a single set of three adder/subtractors. A load strobe copies an input vector (x0, y0) and an angle (a0) into three working registers. The following clocks each rotate the vector by plus or minus arctan(2^-i), where i is the iteration counter. The counter also selects the shift distance and the entry of a computed arctangent table. When the last iteration is done, a one-cycle ready pulse marks the results on xn, yn and an. The engine then idles and holds them until the next load.

A parameter fixes the mode at build time. In rotation mode the vector is turned by a0, so it serves for polar-to-Cartesian conversion, for general rotation, and for sine and cosine: feed x0 = 1/K, y0 = 0, a0 = theta. In vectoring mode the vector is turned onto the positive x axis while the applied angle accumulates into an, which gives the magnitude (scaled by the gain K) and the phase. Linear values are two's complement with 1.0 = 2^(WIDTH-2). Angles are two's complement with pi radians = 2^(WIDTH-1), so pi/2 = 2^(WIDTH-2). Gain correction and number-format conversion are left to the surrounding system.

A clock enable freezes all state. A load strobe accepted during a conversion abandons it and starts over. A synchronous active-high reset returns the engine to idle.

Top module: `cordic_word_serial`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), rdy is 0 and xn, yn and an are all 0.
- R2: A load (ld and ce high at an edge) is followed by exactly ITERS further enabled edges of iteration, and rdy is high in the cycle that follows the ITERS-th of them, which makes ITERS+1 enabled clocks per conversion.
- R3: rdy is high for exactly one enabled clock, and xn, yn and an hold the conversion result while it is high.
- R4: In rotation mode (MODE = MODE_ROTATE, encoding 0), the result is xn = K(x0 cos t - y0 sin t), yn = K(y0 cos t + x0 sin t) and an about 0, with t = a0 * pi / 2^(WIDTH-1), K = prod over i < ITERS of sqrt(1 + 2^-2i), and linear 1.0 = 2^(WIDTH-2), within a few LSB.
- R5: In rotation mode with x0 = round(2^(WIDTH-2)/K) and y0 = 0, xn is cos(t) and yn is sin(t), both scaled by 2^(WIDTH-2), including t = +pi/2 (a0 = 2^(WIDTH-2)).
- R6: In vectoring mode (MODE = MODE_VECTOR, encoding 1) with x0 > 0 and a0 = 0, xn = K sqrt(x0^2 + y0^2), yn is about 0, and an = atan2(y0, x0) in the angle encoding of R4, within a few LSB.
- R7: A load presented in the same cycle as rdy is accepted, and its result follows after the R2 latency counted from that edge.
- R8: A load accepted while a conversion is in progress, including on the edge where the old conversion would have finished, discards it: no rdy pulse appears for the old inputs, and the new result follows after the R2 latency.
- R9: While ce is low, the counter, the working registers and rdy all keep their values, so each disabled edge delays rdy by one cycle and a ready pulse stays high across the disabled edges.
- R10: After a conversion completes, the engine stays idle: no further rdy pulse appears and xn, yn and an stay unchanged until the next accepted load.
- R11: Raising rst during a conversion cancels it: the outputs return to 0 and no rdy pulse follows.
- R12: A load strobe presented while ce is low is ignored: no conversion starts and the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; low freezes all state |
| ld | input | 1 | Load strobe; captures x0, y0, a0 and starts a conversion |
| x0 | input | WIDTH | Initial x (linear, two's complement) |
| y0 | input | WIDTH | Initial y (linear, two's complement) |
| a0 | input | WIDTH | Initial angle (pi = 2^(WIDTH-1)) |
| rdy | output | 1 | One-cycle pulse: results valid |
| xn | output | WIDTH | Final x register |
| yn | output | WIDTH | Final y register |
| an | output | WIDTH | Final angle register |

## Verification
Rotation is tried on vectors in all four quadrants with positive, negative and right-angle turns. A wrong sign choice or a wrong shift distance then shows up as a large error in xn or yn, and a wrong table entry shows up as a residual in an. The sine/cosine pattern (x0 = 1/K, y0 = 0) covers zero, both signs and the +pi/2 edge, and separates a gain or table error from a pure rotation error. A second instance in vectoring mode is fed vectors above, below and on the x axis, which checks the choice of direction from the sign of y and the angle accumulation. The handshake patterns check the ready cycle exactly: back-to-back loads, an abort mid-way and one on the final edge, clock-enable gaps both during iteration and while rdy is high, a load while disabled, and a reset mid-conversion.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  typedef enum logic {
    MODE_ROTATE = 1'b0,
    MODE_VECTOR = 1'b1
  } cordic_mode_e;

  // arctan(2^-i) in radians, by power series for i >= 1
  function automatic real atan_pow2(input int i);
    real x, x2, term, sum;
    if (i == 0) return 0.78539816339744830962;
    x = 1.0;
    for (int j = 0; j < i; j++) x = x / 2.0;
    x2   = x * x;
    term = x;
    sum  = 0.0;
    for (int k = 0; k < 40; k++) begin
      if (k % 2 == 0) sum = sum + term / real'(2 * k + 1);
      else            sum = sum - term / real'(2 * k + 1);
      term = term * x2;
    end
    return sum;
  endfunction

  // angle code with pi radians = 2^(w-1), rounded to nearest
  function automatic longint angle_code(input int i, input int w);
    real v;
    v = atan_pow2(i) / 3.14159265358979323846;
    for (int j = 0; j < w - 1; j++) v = v * 2.0;
    return longint'(v);
  endfunction

endpackage

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom #(
  parameter int WIDTH = 16,
  parameter int ITERS = 16,
  localparam int IDX_W = (ITERS > 1) ? $clog2(ITERS) : 1
) (
  input  logic [IDX_W-1:0] idx,
  output logic [WIDTH-1:0] angle
);

  logic [WIDTH-1:0] atan_tbl [ITERS];

  for (genvar g = 0; g < ITERS; g++) begin : g_entry
    localparam logic [WIDTH-1:0] ENTRY = WIDTH'(cordic_pkg::angle_code(g, WIDTH));
    assign atan_tbl[g] = ENTRY;
  end

  always_comb begin
    angle = '0;
    for (int k = 0; k < ITERS; k++) begin
      if (idx == IDX_W'(k)) angle = atan_tbl[k];
    end
  end

endmodule

// File: rtl/cordic_addsub.sv
module cordic_addsub #(
  parameter int WIDTH = 16
) (
  input  logic signed [WIDTH-1:0] a,
  input  logic signed [WIDTH-1:0] b,
  input  logic                    sub,
  output logic signed [WIDTH-1:0] y
);

  assign y = sub ? (a - b) : (a + b);

endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl #(
  parameter int ITERS = 16,
  localparam int IDX_W = (ITERS > 1) ? $clog2(ITERS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             ld,
  output logic             load_en,
  output logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             rdy
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ITERS - 1);

  logic             busy;
  logic [IDX_W-1:0] cnt;

  assign load_en = ce & ld;
  assign step    = ce & busy & ~ld;
  assign idx     = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      rdy  <= 1'b0;
    end else if (ce) begin
      if (ld) begin
        busy <= 1'b1;
        cnt  <= '0;
        rdy  <= 1'b0;
      end else if (busy) begin
        rdy <= (cnt == LAST);
        if (cnt == LAST) busy <= 1'b0;
        else             cnt  <= cnt + 1'b1;
      end else begin
        rdy <= 1'b0;
      end
    end
  end

  // R3
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy && ce) |=> !rdy);

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(cnt) && $stable(busy) && $stable(rdy)));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && ld) |=> (busy && cnt == '0 && !rdy));

  // R2
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && busy && !ld && cnt == LAST) |=> (rdy && !busy));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(ce && ld)) |=> !busy);

endmodule

// File: rtl/cordic_datapath.sv
module cordic_datapath #(
  parameter int WIDTH = 16,
  parameter int ITERS = 16,
  parameter cordic_pkg::cordic_mode_e MODE = cordic_pkg::MODE_ROTATE,
  localparam int IDX_W = (ITERS > 1) ? $clog2(ITERS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_en,
  input  logic                    step,
  input  logic [IDX_W-1:0]        idx,
  input  logic signed [WIDTH-1:0] step_angle,
  input  logic signed [WIDTH-1:0] x0,
  input  logic signed [WIDTH-1:0] y0,
  input  logic signed [WIDTH-1:0] a0,
  output logic signed [WIDTH-1:0] x_q,
  output logic signed [WIDTH-1:0] y_q,
  output logic signed [WIDTH-1:0] a_q
);

  logic                    up;
  logic signed [WIDTH-1:0] x_sh, y_sh, x_nx, y_nx, a_nx;

  // direction: up = counter-clockwise micro-rotation
  if (MODE == cordic_pkg::MODE_VECTOR) begin : g_vec
    assign up = y_q[WIDTH-1];
  end else begin : g_rot
    assign up = ~a_q[WIDTH-1];
  end

  assign x_sh = x_q >>> idx;
  assign y_sh = y_q >>> idx;

  cordic_addsub #(.WIDTH(WIDTH)) u_x (.a(x_q), .b(y_sh),       .sub(up),  .y(x_nx));
  cordic_addsub #(.WIDTH(WIDTH)) u_y (.a(y_q), .b(x_sh),       .sub(~up), .y(y_nx));
  cordic_addsub #(.WIDTH(WIDTH)) u_a (.a(a_q), .b(step_angle), .sub(up),  .y(a_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
      a_q <= '0;
    end else if (load_en) begin
      x_q <= x0;
      y_q <= y0;
      a_q <= a0;
    end else if (step) begin
      x_q <= x_nx;
      y_q <= y_nx;
      a_q <= a_nx;
    end
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (x_q == $past(x0) && y_q == $past(y0) && a_q == $past(a0)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !step) |=> ($stable(x_q) && $stable(y_q) && $stable(a_q)));

endmodule

// File: rtl/cordic_word_serial.sv
module cordic_word_serial #(
  parameter int WIDTH = 16,
  parameter int ITERS = 16,
  parameter cordic_pkg::cordic_mode_e MODE = cordic_pkg::MODE_ROTATE
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  logic                    ld,
  input  logic signed [WIDTH-1:0] x0,
  input  logic signed [WIDTH-1:0] y0,
  input  logic signed [WIDTH-1:0] a0,
  output logic                    rdy,
  output logic signed [WIDTH-1:0] xn,
  output logic signed [WIDTH-1:0] yn,
  output logic signed [WIDTH-1:0] an
);

  localparam int IDX_W = (ITERS > 1) ? $clog2(ITERS) : 1;

  logic             load_en, step;
  logic [IDX_W-1:0] idx;
  logic [WIDTH-1:0] step_angle;

  cordic_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk(clk), .rst(rst), .ce(ce), .ld(ld),
    .load_en(load_en), .step(step), .idx(idx), .rdy(rdy)
  );

  cordic_atan_rom #(.WIDTH(WIDTH), .ITERS(ITERS)) u_rom (
    .idx(idx), .angle(step_angle)
  );

  cordic_datapath #(.WIDTH(WIDTH), .ITERS(ITERS), .MODE(MODE)) u_dp (
    .clk(clk), .rst(rst), .load_en(load_en), .step(step), .idx(idx),
    .step_angle(step_angle), .x0(x0), .y0(y0), .a0(a0),
    .x_q(xn), .y_q(yn), .a_q(an)
  );

endmodule

// File: tb/cordic_word_serial_tb.sv
module cordic_word_serial_tb;

  localparam int  W     = 16;
  localparam int  N     = 16;
  localparam real ONE   = 16384.0;
  localparam real ASCL  = 32768.0;
  localparam real PI    = 3.14159265358979323846;
  localparam real TOL   = 24.0;

  logic clk = 1'b0, rst = 1'b1, ce = 1'b1, ld = 1'b0, vld = 1'b0;
  logic signed [W-1:0] x0 = '0, y0 = '0, a0 = '0, vx0 = '0, vy0 = '0;
  logic signed [W-1:0] va0 = '0;
  logic rdy, vrdy;
  logic signed [W-1:0] xn, yn, an, vxn, vyn, van;

  cordic_word_serial #(.WIDTH(W), .ITERS(N), .MODE(cordic_pkg::MODE_ROTATE)) u_dut (
    .clk(clk), .rst(rst), .ce(ce), .ld(ld), .x0(x0), .y0(y0), .a0(a0),
    .rdy(rdy), .xn(xn), .yn(yn), .an(an));

  cordic_word_serial #(.WIDTH(W), .ITERS(N), .MODE(cordic_pkg::MODE_VECTOR)) u_dut_vec (
    .clk(clk), .rst(rst), .ce(ce), .ld(vld), .x0(vx0), .y0(vy0), .a0(va0),
    .rdy(vrdy), .xn(vxn), .yn(vyn), .an(van));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  checks = 0, errors = 0;
  bit  done = 1'b0;
  real kg;

  real   ex_q[$], ey_q[$], ea_q[$];
  int    due_q[$];
  string tag_q[$];
  real   vx_q[$], va_q[$];
  int    vdue_q[$];
  string vtag_q[$];

  task automatic chk_near(string tag, string what, int act, real exp);
    real d;
    checks++;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    if (d > TOL) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0.1f", tag, what, act, exp);
    end
  endtask

  task automatic chk_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wait_drain();
    while (ex_q.size() != 0 || vx_q.size() != 0) tick(1);
    tick(2);
  endtask

  function automatic int q_lin(real v);
    return int'(v * ONE);
  endfunction

  function automatic int q_ang(real r);
    return int'(r / PI * ASCL);
  endfunction

  // driver for the rotation engine: one-cycle load, expected result queued
  task automatic rot_go(int x, int y, int a, bit push, int gaps, string tag, output int due);
    real th;
    x0 = W'(x); y0 = W'(y); a0 = W'(a); ld = 1'b1;
    due = cyc + 1 + N + gaps;
    if (push) begin
      th = real'(a) * PI / ASCL;
      ex_q.push_back(kg * (real'(x) * $cos(th) - real'(y) * $sin(th)));
      ey_q.push_back(kg * (real'(y) * $cos(th) + real'(x) * $sin(th)));
      ea_q.push_back(0.0);
      due_q.push_back(due);
      tag_q.push_back(tag);
    end
    tick(1);
    ld = 1'b0;
  endtask

  task automatic vec_go(int x, int y, string tag);
    vx0 = W'(x); vy0 = W'(y); vld = 1'b1;
    vx_q.push_back(kg * $sqrt(real'(x) * real'(x) + real'(y) * real'(y)));
    va_q.push_back($atan2(real'(y), real'(x)) / PI * ASCL);
    vdue_q.push_back(cyc + 1 + N);
    vtag_q.push_back(tag);
    tick(1);
    vld = 1'b0;
  endtask

  // monitor: rotation engine
  bit prev_rdy = 1'b0, prev_ce = 1'b1;
  int last_x, last_y, last_a;
  always @(negedge clk) begin
    if (rst) prev_rdy = 1'b0;
    else begin
      if (rdy) begin
        if (prev_rdy && !prev_ce) begin
          chk_eq("R9", "held xn", int'(xn), last_x);
          chk_eq("R9", "held yn", int'(yn), last_y);
        end else if (prev_rdy) begin
          chk_eq("R3", "rdy width", 2, 1);
        end else if (ex_q.size() == 0) begin
          chk_eq("R8 R10 R11", "unexpected rdy", 1, 0);
        end else begin
          real   ex, ey, ea;
          int    due;
          string tag;
          ex = ex_q.pop_front(); ey = ey_q.pop_front(); ea = ea_q.pop_front();
          due = due_q.pop_front(); tag = tag_q.pop_front();
          chk_eq({tag, " R2"}, "ready cycle", cyc, due);
          chk_near(tag, "xn", int'(xn), ex);
          chk_near(tag, "yn", int'(yn), ey);
          chk_near(tag, "an", int'(an), ea);
          last_x = int'(xn); last_y = int'(yn); last_a = int'(an);
        end
      end
      prev_rdy = rdy;
      prev_ce  = ce;
    end
  end

  // monitor: vectoring engine
  bit vprev_rdy = 1'b0, vprev_ce = 1'b1;
  always @(negedge clk) begin
    if (rst) vprev_rdy = 1'b0;
    else begin
      if (vrdy && !(vprev_rdy && !vprev_ce)) begin
        if (vprev_rdy) chk_eq("R3", "vec rdy width", 2, 1);
        else if (vx_q.size() == 0) chk_eq("R10", "vec unexpected rdy", 1, 0);
        else begin
          real   ex, ea;
          int    due;
          string tag;
          ex = vx_q.pop_front(); ea = va_q.pop_front();
          due = vdue_q.pop_front(); tag = vtag_q.pop_front();
          chk_eq({tag, " R2"}, "vec ready cycle", cyc, due);
          chk_near(tag, "vec xn", int'(vxn), ex);
          chk_near(tag, "vec yn", int'(vyn), 0.0);
          chk_near(tag, "vec an", int'(van), ea);
        end
      end
      vprev_rdy = vrdy;
      vprev_ce  = ce;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual %0d cycles expected fewer", cyc);
    finish_run();
  end

  initial begin
    int d, d2, kx, sx, sy, sa;
    kg = 1.0;
    for (int i = 0; i < N; i++) kg = kg * $sqrt(1.0 + 1.0 / (4.0 ** i));

    // R1: reset state
    tick(3);
    chk_eq("R1", "rdy", int'(rdy), 0);
    chk_eq("R1", "xn", int'(xn), 0);
    chk_eq("R1", "yn", int'(yn), 0);
    chk_eq("R1", "an", int'(an), 0);
    chk_eq("R1", "vec rdy", int'(vrdy), 0);
    rst = 1'b0;
    tick(2);

    // R4: general rotation in several quadrants
    rot_go(q_lin(0.5),  0,            q_ang(PI/4),  1'b1, 0, "R4", d); wait_drain();
    rot_go(q_lin(0.3),  q_lin(-0.4),  q_ang(-PI/3), 1'b1, 0, "R4", d); wait_drain();
    rot_go(0,           q_lin(0.5),   q_ang(PI/2),  1'b1, 0, "R4", d); wait_drain();
    rot_go(q_lin(-0.5), q_lin(0.2),   q_ang(0.1),   1'b1, 0, "R4", d); wait_drain();

    // R5: sine and cosine with x0 = 1/K
    kx = int'(ONE / kg);
    rot_go(kx, 0, 0,              1'b1, 0, "R5", d); wait_drain();
    rot_go(kx, 0, q_ang(PI/6),    1'b1, 0, "R5", d); wait_drain();
    rot_go(kx, 0, q_ang(-PI/4),   1'b1, 0, "R5", d); wait_drain();
    rot_go(kx, 0, 16384,          1'b1, 0, "R5", d); wait_drain();
    rot_go(kx, 0, q_ang(-PI/3),   1'b1, 0, "R5", d); wait_drain();

    // R7: back-to-back, next load in the ready cycle
    rot_go(q_lin(0.4), q_lin(0.1), q_ang(0.7), 1'b1, 0, "R7", d);
    while (cyc < d) tick(1);
    rot_go(q_lin(-0.2), q_lin(0.45), q_ang(-1.2), 1'b1, 0, "R7", d2);
    wait_drain();

    // R8: abort in mid conversion
    rot_go(q_lin(0.5), 0, q_ang(1.0), 1'b0, 0, "R8", d);
    tick(5);
    rot_go(q_lin(0.2), q_lin(0.3), q_ang(-0.5), 1'b1, 0, "R8", d2);
    wait_drain();
    // R8: abort on the edge that would have finished
    rot_go(q_lin(0.5), 0, q_ang(1.0), 1'b0, 0, "R8", d);
    while (cyc < d - 1) tick(1);
    rot_go(q_lin(-0.3), q_lin(-0.3), q_ang(0.3), 1'b1, 0, "R8", d2);
    wait_drain();

    // R9: clock enable gap during iteration, then during ready
    rot_go(q_lin(0.35), q_lin(0.25), q_ang(0.9), 1'b1, 7, "R9", d);
    tick(3);
    ce = 1'b0;
    tick(7);
    ce = 1'b1;
    while (cyc < d) tick(1);
    ce = 1'b0;
    tick(3);
    chk_eq("R9", "rdy held while disabled", int'(rdy), 1);
    ce = 1'b1;
    tick(1);
    chk_eq("R3", "rdy after enabled ready cycle", int'(rdy), 0);
    wait_drain();

    // R10: idle after completion
    sx = int'(xn); sy = int'(yn); sa = int'(an);
    tick(40);
    chk_eq("R10", "idle xn", int'(xn), sx);
    chk_eq("R10", "idle yn", int'(yn), sy);
    chk_eq("R10", "idle an", int'(an), sa);

    // R12: load while disabled is ignored
    ce = 1'b0; ld = 1'b1;
    x0 = W'(q_lin(0.1)); y0 = W'(q_lin(0.1)); a0 = W'(q_ang(0.2));
    tick(2);
    ce = 1'b1; ld = 1'b0;
    tick(N + 4);
    chk_eq("R12", "xn unchanged", int'(xn), sx);
    chk_eq("R12", "an unchanged", int'(an), sa);
    chk_eq("R12", "rdy", int'(rdy), 0);

    // R11: synchronous reset in mid conversion
    rot_go(q_lin(0.5), q_lin(0.1), q_ang(0.4), 1'b0, 0, "R11", d);
    tick(4);
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    chk_eq("R11", "xn after reset", int'(xn), 0);
    chk_eq("R11", "rdy after reset", int'(rdy), 0);
    tick(N + 4);
    chk_eq("R11", "xn stays cleared", int'(xn), 0);

    // R6: vectoring mode
    vec_go(q_lin(0.5), q_lin(0.3),   "R6"); wait_drain();
    vec_go(q_lin(0.2), q_lin(-0.5),  "R6"); wait_drain();
    vec_go(q_lin(0.6), 0,            "R6"); wait_drain();
    vec_go(q_lin(0.1), q_lin(0.55),  "R6"); wait_drain();

    tick(4);
    finish_run();
  end

endmodule